// File: doc/BRIEF.md
# Coherent-Read Timestamp Counter

A free-running timestamp counter, 40 bits wide by default, read over a 32-bit register bus. The count advances by one on every cycle in which the single-cycle tick-enable input is high and counting is switched on. The tick source is outside the block, with a nominal rate near 983 kHz. The block has no interrupt output.

The count is wider than a bus word, so software reads it in two accesses: first the low word, then the high register. The read of the low word also copies the upper count bits into a holding byte. The later read of the high register returns that byte and not the live upper bits. The joined value is therefore the count as it stood at the low-word read, even if ticks arrive between the two accesses. The run/stop switch is one bit in the high register, so it shares that register with the held byte.

Reads return data one cycle after the request. Writes take effect at the clock edge of the request.

Top module: `tstamp_ctr`

## Requirements
- R1: After reset the count, the held upper byte and the run bit are all zero, so reads of both the low word and the high register return 0.
- R2: While the run bit is 1, the count rises by exactly one at each clock edge where tick_i is 1, and keeps its value at every edge where tick_i is 0.
- R3: While the run bit is 0, ticks have no effect on the count. Setting the run bit again resumes counting from the value that was held.
- R4: A read at offset LO_OFS (0x60) returns count bits [DATA_W-1:0] on bus_rdata_o one cycle after the request. When a tick lands in the same cycle as the read, the value returned is the count from before that tick.
- R5: A read at LO_OFS loads the held byte with count bits [CNT_W-1:DATA_W], taken from the count before any tick in the same cycle.
- R6: A read at offset HI_OFS (0x64) returns the held byte in bits [CNT_W-DATA_W-1:0] and the run bit in bit EN_BIT (8). All other bits read as zero. The read does not change the held byte.
- R7: A write to HI_OFS sets the run bit to bus_wdata_i[EN_BIT]. Writes to LO_OFS or to any other offset change nothing. Reads at any offset other than LO_OFS and HI_OFS return 0.
- R8: After the count reaches all ones, the next counted tick wraps it to zero.
- R9: The held byte keeps its value until the next read at LO_OFS, however far the count advances. A low-word read followed by a high-register read therefore gives the exact count as it stood at the low-word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Single-cycle count enable (the time-base tick) |
| bus_sel_i | input | 1 | Register access request this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid the cycle after a read request; holds otherwise |

## Verification
The hardest case to reach is a tear: a carry out of the low word that happens between the two halves of a read. A second hard case is a tick landing in the very cycle of the low-word read. The bench uses a narrow configuration, with an 8-bit word and a 12-bit count. In that configuration it sweeps the whole count range, including the wrap. Each step is a low-word read followed by a high-register read. A tick is always sent during the high-register read, and a tick is sent during every other low-word read. Every low-word carry and the wrap are therefore crossed with both tick alignments, and each joined value is compared with an arithmetic model of the count.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
  typedef enum logic [2:0] {
    ACC_NONE   = 3'd0,
    ACC_LO_RD  = 3'd1,
    ACC_HI_RD  = 3'd2,
    ACC_HI_WR  = 3'd3,
    ACC_OTH_RD = 3'd4
  } acc_e;
endpackage

// File: rtl/tstamp_decode.sv
module tstamp_decode
  import tstamp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_OFS = 8'h60,
  parameter logic [ADDR_W-1:0] HI_OFS = 8'h64
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_e              acc_o
);
  always_comb begin
    acc_o = ACC_NONE;
    if (sel_i) begin
      if (wr_i) begin
        if (addr_i == HI_OFS) acc_o = ACC_HI_WR;
      end else if (addr_i == LO_OFS) begin
        acc_o = ACC_LO_RD;
      end else if (addr_i == HI_OFS) begin
        acc_o = ACC_HI_RD;
      end else begin
        acc_o = ACC_OTH_RD;
      end
    end
  end
endmodule

// File: rtl/tstamp_count.sv
module tstamp_count #(
  parameter int unsigned CNT_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_wr_i,
  input  logic             en_val_i,
  output logic             en_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             en_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
    end else if (en_wr_i) begin
      en_q <= en_val_i;
    end
  end

  // run bit seen before the edge gates the tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (en_q && tick_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign en_o  = en_q;
  assign cnt_o = cnt_q;

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && tick_i) |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_q && tick_i) |=> $stable(cnt_q)); // R3
  AST_RUN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr_i |=> en_q == $past(en_val_i)); // R7
  AST_RUN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_wr_i |=> $stable(en_q)); // R7
endmodule

// File: rtl/tstamp_snap.sv
module tstamp_snap #(
  parameter int unsigned HI_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cap_i,
  input  logic [HI_W-1:0] cnt_hi_i,
  output logic [HI_W-1:0] held_o
);
  logic [HI_W-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
    end else if (cap_i) begin
      held_q <= cnt_hi_i;
    end
  end

  assign held_o = held_q;

  AST_SNAP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> held_q == $past(cnt_hi_i)); // R5
  AST_SNAP_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(held_q)); // R9
endmodule

// File: rtl/tstamp_rdmux.sv
module tstamp_rdmux
  import tstamp_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HI_W   = 8,
  parameter int unsigned EN_BIT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_e              acc_i,
  input  logic [DATA_W-1:0] cnt_lo_i,
  input  logic [HI_W-1:0]   held_i,
  input  logic              en_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] hi_word;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    hi_word = '0;
    for (int i = 0; i < int'(HI_W); i++) hi_word[i] = held_i[i];
    hi_word[EN_BIT] = en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else begin
      case (acc_i)
        ACC_LO_RD:  rdata_q <= cnt_lo_i;
        ACC_HI_RD:  rdata_q <= hi_word;
        ACC_OTH_RD: rdata_q <= '0;
        default:    rdata_q <= rdata_q;
      endcase
    end
  end

  assign rdata_o = rdata_q;

  AST_LO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == ACC_LO_RD) |=> rdata_q == $past(cnt_lo_i)); // R4
  AST_HI_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == ACC_HI_RD) |=> rdata_q[EN_BIT] == $past(en_i)); // R6
  AST_OTH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == ACC_OTH_RD) |=> rdata_q == '0); // R7
endmodule

// File: rtl/tstamp_ctr.sv
module tstamp_ctr
  import tstamp_pkg::*;
#(
  parameter int unsigned CNT_W  = 40,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned EN_BIT = 8,
  parameter logic [ADDR_W-1:0] LO_OFS = 8'h60,
  parameter logic [ADDR_W-1:0] HI_OFS = 8'h64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o
);
  localparam int unsigned HI_W = CNT_W - DATA_W;

  acc_e             acc;
  logic             en;
  logic [CNT_W-1:0] cnt;
  logic [HI_W-1:0]  held;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata_i;

  tstamp_decode #(.ADDR_W(ADDR_W), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS)) u_dec (
    .sel_i (bus_sel_i),
    .wr_i  (bus_wr_i),
    .addr_i(bus_addr_i),
    .acc_o (acc)
  );

  tstamp_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .en_wr_i (acc == ACC_HI_WR),
    .en_val_i(bus_wdata_i[EN_BIT]),
    .en_o    (en),
    .cnt_o   (cnt)
  );

  tstamp_snap #(.HI_W(HI_W)) u_snap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (acc == ACC_LO_RD),
    .cnt_hi_i(cnt[CNT_W-1:DATA_W]),
    .held_o  (held)
  );

  tstamp_rdmux #(.DATA_W(DATA_W), .HI_W(HI_W), .EN_BIT(EN_BIT)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (acc),
    .cnt_lo_i(cnt[DATA_W-1:0]),
    .held_i  (held),
    .en_i    (en),
    .rdata_o (bus_rdata_o)
  );

  AST_NO_TICK_NO_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt)); // R2
endmodule

// File: tb/sim_tstamp_ctr.sv
module sim_tstamp_ctr;
  localparam int CW = 12;
  localparam int DW = 8;
  localparam int HW = CW - DW;
  localparam int EB = 7;
  localparam logic [7:0] LO = 8'h60;
  localparam logic [7:0] HI = 8'h64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic sel = 1'b0;
  logic wr = 1'b0;
  logic [7:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  int m_cnt = 0;
  int m_held = 0;
  int m_en = 0;

  always #2.5 clk = ~clk;

  tstamp_ctr #(.CNT_W(CW), .DATA_W(DW), .ADDR_W(8), .EN_BIT(EB),
               .LO_OFS(LO), .HI_OFS(HI)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_sel_i(sel),
    .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one bus cycle; the model advances with the pre-edge state
  task automatic op(input logic s, input logic w, input logic [7:0] a,
                    input int wd, input logic t, output int exp);
    int nc, nh, ne;
    sel = s; wr = w; addr = a; wdata = DW'(wd); tick = t;
    exp = -1;
    nc = m_cnt; nh = m_held; ne = m_en;
    if (s && !w) begin
      if (a == LO) begin
        exp = m_cnt % (1 << DW);
        nh = m_cnt >> DW;
      end else if (a == HI) begin
        exp = m_held | (m_en << EB);
      end else begin
        exp = 0;
      end
    end
    if (s && w && a == HI) ne = (wd >> EB) & 1;
    if (m_en == 1 && t) nc = (m_cnt + 1) % (1 << CW);
    @(posedge clk);
    m_cnt = nc; m_held = nh; m_en = ne;
    @(negedge clk);
    sel = 0; wr = 0; tick = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic t, input string req);
    int e;
    op(1, 0, a, 0, t, e);
    check(req, int'(rdata), e);
  endtask

  task automatic idle(input int n, input logic t);
    int e;
    for (int i = 0; i < n; i++) op(0, 0, 8'h00, 0, t, e);
  endtask

  task automatic wr_reg(input logic [7:0] a, input int wd);
    int e;
    op(1, 1, a, wd, 0, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int lo_v, hi_v, comb, prev, wraps, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(LO, 0, "R1 low after reset");
    rd(HI, 0, "R1 high after reset");

    idle(5, 1);
    rd(LO, 0, "R3 ticks ignored while stopped");

    wr_reg(HI, 'hff);
    rd(HI, 0, "R7 run bit set by high write");
    check("R6 high word shows run bit", int'(rdata), 1 << EB);

    idle(10, 1);
    rd(LO, 0, "R2 ten ticks counted");
    check("R2 count value", int'(rdata), 10);
    idle(5, 0);
    rd(LO, 0, "R2 no tick no change");

    wr_reg(LO, 'hff);
    rd(LO, 0, "R7 low write ignored");
    rd(8'h10, 0, "R7 other offset reads zero");
    wr_reg(8'h20, 0);
    rd(HI, 0, "R7 other offset write ignored");

    wr_reg(HI, 'h7f);
    idle(7, 1);
    rd(LO, 0, "R3 held while stopped");
    rd(HI, 0, "R6 run bit clear, upper bits zero");
    wr_reg(HI, 1 << EB);
    idle(3, 1);
    rd(LO, 0, "R3 resume from held value");
    check("R3 resumed count", int'(rdata), 13);

    idle(300, 1);
    rd(LO, 1, "R4 low read with same-cycle tick");
    rd(HI, 0, "R5 held byte from pre-tick count");
    idle(20, 1);
    rd(HI, 1, "R9 held byte unchanged by counting");
    rd(HI, 0, "R6 high read leaves held byte");

    // full sweep across every carry and the wrap
    prev = -1; wraps = 0;
    for (int i = 0; i < 3000; i++) begin
      e = m_cnt;
      op(1, 0, LO, 0, logic'(i & 1), lo_v);
      check("R4 sweep low", int'(rdata), lo_v);
      lo_v = int'(rdata);
      op(1, 0, HI, 0, 1'b1, hi_v);
      check("R5 sweep high", int'(rdata), hi_v);
      hi_v = int'(rdata) & ((1 << HW) - 1);
      comb = (hi_v << DW) | lo_v;
      check("R9 coherent joined value", comb, e);
      if (prev >= 0 && comb < prev) begin
        wraps++;
        check("R8 wrap lands near zero", int'(comb < 4), 1);
      end
      prev = comb;
    end
    check("R8 exactly one wrap in sweep", wraps, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule